// File: doc/BRIEF.md
# Two-Level Logic Array with Crosspoint and Line Fault Injection

The block is a programmable sum-of-products array. A configurable AND plane forms product terms from the true and complemented forms of the primary inputs. A configurable OR plane then combines those product terms into the outputs. Software-free configuration goes through a one-bit write port: the caller selects a plane, a row and a column, and gives the new crosspoint value. Evaluation is purely combinational.

Two copies of the evaluator share the stored planes. The reference copy always computes the programmed function. The second copy applies one run-time fault, taken from the injection port. That fault can flip a single crosspoint in either plane, hold one line at 0 or 1, or short two neighbouring lines of the same class with wired-AND or wired-OR behaviour. The block reports both output vectors and a difference flag, so a test pattern can be graded against a chosen fault in one evaluation. A registered copy of all three results is also provided.

Top module: `pla_fault_array`

## Requirements
- R1: After reset, every crosspoint in both planes is cleared, so both output vectors read all zeros for any input.
- R2: A write with `cfg_plane`=0 sets the AND-plane crosspoint at product `cfg_row` and literal `cfg_col`. Literal c < N_IN is input c true, and literal c ≥ N_IN is input c−N_IN complemented. A write with `cfg_plane`=1 sets the OR-plane crosspoint at output `cfg_row`, product `cfg_col`. The write takes effect on the next rising clock. Writes outside the plane are ignored. A product with no literals evaluates to 1.
- R3: With `flt_en`=0, the faulty output equals the reference output whatever the other fault inputs hold.
- R4: Kind 0 (`flt_kind`=0) toggles the AND-plane crosspoint at `flt_row`/`flt_col`. Toggling off a programmed literal removes it from the product, which then covers more minterms.
- R5: Kind 0 on an unprogrammed AND crosspoint adds the literal, which narrows the product. If the product then holds a variable and its complement, the product is constant 0.
- R6: Kind 1 toggles the OR-plane crosspoint at output `flt_row`, product `flt_col`. Removing a connection drops that product from that output.
- R7: Kind 1 on an unconnected OR crosspoint adds that product to that output.
- R8: Kind 2 holds the line selected by `flt_cls`/`flt_idx` at `flt_val`. Class 0 is a primary input line before its inverter, so both polarities of that input follow the held value.
- R9: Class 1 with kind 2 holds only the complemented literal of input `flt_idx`. The true literal is unaffected.
- R10: Kind 2 also applies to product lines (class 2) and output lines (class 3). An index beyond the class's line count has no effect.
- R11: Kind 3 shorts line `flt_idx` and line `flt_idx`+1 of class `flt_cls`. Both lines then carry their AND (`flt_val`=0) or their OR (`flt_val`=1). If line `flt_idx`+1 does not exist, the short has no effect.
- R12: `diff_o` is high exactly when the two output vectors differ. `good_q`, `bad_q` and `diff_q` repeat `good_o`, `bad_o` and `diff_o` one clock later.
- R13: The reference output depends only on the inputs and the stored planes, never on the fault inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Crosspoint write strobe |
| cfg_plane | input | 1 | 0 = AND plane, 1 = OR plane |
| cfg_row | input | SEL_W | Product (AND) or output (OR) row |
| cfg_col | input | SEL_W | Literal (AND) or product (OR) column |
| cfg_bit | input | 1 | New crosspoint value |
| pi | input | N_IN | Primary inputs |
| flt_en | input | 1 | Enables the single injected fault |
| flt_kind | input | 2 | 0 AND toggle, 1 OR toggle, 2 stuck, 3 bridge |
| flt_cls | input | 2 | Line class: 0 input, 1 inverter out, 2 product, 3 output |
| flt_row | input | SEL_W | Crosspoint row for kinds 0/1 |
| flt_col | input | SEL_W | Crosspoint column for kinds 0/1 |
| flt_idx | input | SEL_W | Line index for kinds 2/3 |
| flt_val | input | 1 | Stuck value, or bridge mode (0 AND, 1 OR) |
| good_o | output | N_OUT | Reference outputs |
| bad_o | output | N_OUT | Outputs with the fault applied |
| diff_o | output | 1 | High when the two vectors differ |
| good_q | output | N_OUT | Registered reference outputs |
| bad_q | output | N_OUT | Registered faulty outputs |
| diff_q | output | 1 | Registered difference flag |

## Verification
A wrong stored crosspoint changes `good_o` itself, which can be seen as soon as an input vector sensitises that product term. The bench therefore sweeps all input combinations after programming. A wrong decode of the fault port makes `bad_o` and `diff_o` differ from an independent model in the same cycle as the vector. The registered copies then expose the same error one clock later. Every fault class is swept over the full input space, so any vector that separates the intended fault from the applied one is found.

// File: rtl/pla_pkg.sv
package pla_pkg;
   typedef enum logic [1:0] {
      FK_XP_AND = 2'd0,
      FK_XP_OR  = 2'd1,
      FK_STUCK  = 2'd2,
      FK_BRIDGE = 2'd3
   } fault_kind_e;

   typedef enum logic [1:0] {
      LC_INPUT = 2'd0,
      LC_INV   = 2'd1,
      LC_PROD  = 2'd2,
      LC_OUT   = 2'd3
   } line_cls_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int sel_width(input int n_in, input int n_pt, input int n_out);
      int m;
      m = max3(2 * n_in, n_pt, n_out);
      return (m < 2) ? 1 : $clog2(m);
   endfunction
endpackage

// File: rtl/pla_plane_store.sv
module pla_plane_store #(
   parameter int N_IN  = 4,
   parameter int N_PT  = 8,
   parameter int N_OUT = 3,
   parameter int SEL_W = 3
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             we,
   input  logic                             plane,
   input  logic [SEL_W-1:0]                 row,
   input  logic [SEL_W-1:0]                 col,
   input  logic                             bitv,
   output logic [N_PT-1:0][2*N_IN-1:0]      and_mask,
   output logic [N_OUT-1:0][N_PT-1:0]       or_mask
);
   localparam int N_LIT = 2 * N_IN;

   always_ff @(posedge clk) begin
      if (rst) begin
         and_mask <= '0;
         or_mask  <= '0;
      end else if (we) begin
         for (int r = 0; r < N_PT; r++)
            for (int c = 0; c < N_LIT; c++)
               if (!plane && int'(row) == r && int'(col) == c)
                  and_mask[r][c] <= bitv;
         for (int r = 0; r < N_OUT; r++)
            for (int c = 0; c < N_PT; c++)
               if (plane && int'(row) == r && int'(col) == c)
                  or_mask[r][c] <= bitv;
      end
   end

   a_r1_planes_cleared : assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (and_mask == '0 && or_mask == '0));

   a_r2_and_write_lands : assert property (@(posedge clk) disable iff (rst)
      (we && !plane && int'(row) < N_PT && int'(col) < N_LIT)
      |=> (and_mask[$past(row)][$past(col)] == $past(bitv)));

   a_r2_or_write_lands : assert property (@(posedge clk) disable iff (rst)
      (we && plane && int'(row) < N_OUT && int'(col) < N_PT)
      |=> (or_mask[$past(row)][$past(col)] == $past(bitv)));
endmodule

// File: rtl/pla_fault_ctl.sv
module pla_fault_ctl
   import pla_pkg::*;
#(
   parameter int N_IN  = 4,
   parameter int N_PT  = 8,
   parameter int N_OUT = 3,
   parameter int SEL_W = 3
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        en,
   input  logic [1:0]                  kind,
   input  logic [1:0]                  cls,
   input  logic [SEL_W-1:0]            row,
   input  logic [SEL_W-1:0]            col,
   input  logic [SEL_W-1:0]            idx,
   input  logic                        val,
   input  logic [N_PT-1:0][2*N_IN-1:0] and_mask,
   input  logic [N_OUT-1:0][N_PT-1:0]  or_mask,
   output logic [N_PT-1:0][2*N_IN-1:0] and_mask_f,
   output logic [N_OUT-1:0][N_PT-1:0]  or_mask_f,
   output logic [N_IN-1:0]             in_sm,
   output logic [N_IN-1:0]             inv_sm,
   output logic [N_PT-1:0]             pt_sm,
   output logic [N_OUT-1:0]            out_sm,
   output logic                        stuck_val,
   output logic [N_IN-2:0]             in_br,
   output logic [N_IN-2:0]             inv_br,
   output logic [N_PT-2:0]             pt_br,
   output logic [N_OUT-2:0]            out_br,
   output logic                        br_or
);
   localparam int N_LIT = 2 * N_IN;

   fault_kind_e fk;
   line_cls_e   lc;
   logic        is_stuck, is_bridge;

   assign fk        = fault_kind_e'(kind);
   assign lc        = line_cls_e'(cls);
   assign is_stuck  = en && (fk == FK_STUCK);
   assign is_bridge = en && (fk == FK_BRIDGE);
   assign stuck_val = val;
   assign br_or     = val;

   always_comb begin
      and_mask_f = and_mask;
      or_mask_f  = or_mask;
      if (en && fk == FK_XP_AND) begin
         for (int r = 0; r < N_PT; r++)
            for (int c = 0; c < N_LIT; c++)
               if (int'(row) == r && int'(col) == c)
                  and_mask_f[r][c] = ~and_mask[r][c];
      end
      if (en && fk == FK_XP_OR) begin
         for (int r = 0; r < N_OUT; r++)
            for (int c = 0; c < N_PT; c++)
               if (int'(row) == r && int'(col) == c)
                  or_mask_f[r][c] = ~or_mask[r][c];
      end
   end

   always_comb begin
      in_sm  = '0;
      inv_sm = '0;
      pt_sm  = '0;
      out_sm = '0;
      for (int i = 0; i < N_IN; i++) begin
         if (is_stuck && lc == LC_INPUT && int'(idx) == i) in_sm[i]  = 1'b1;
         if (is_stuck && lc == LC_INV   && int'(idx) == i) inv_sm[i] = 1'b1;
      end
      for (int i = 0; i < N_PT; i++)
         if (is_stuck && lc == LC_PROD && int'(idx) == i) pt_sm[i] = 1'b1;
      for (int i = 0; i < N_OUT; i++)
         if (is_stuck && lc == LC_OUT && int'(idx) == i) out_sm[i] = 1'b1;
   end

   always_comb begin
      in_br  = '0;
      inv_br = '0;
      pt_br  = '0;
      out_br = '0;
      for (int i = 0; i < N_IN - 1; i++) begin
         if (is_bridge && lc == LC_INPUT && int'(idx) == i) in_br[i]  = 1'b1;
         if (is_bridge && lc == LC_INV   && int'(idx) == i) inv_br[i] = 1'b1;
      end
      for (int i = 0; i < N_PT - 1; i++)
         if (is_bridge && lc == LC_PROD && int'(idx) == i) pt_br[i] = 1'b1;
      for (int i = 0; i < N_OUT - 1; i++)
         if (is_bridge && lc == LC_OUT && int'(idx) == i) out_br[i] = 1'b1;
   end

   a_r3_masks_pass_when_off : assert property (@(posedge clk) disable iff (rst)
      !en |-> (and_mask_f == and_mask && or_mask_f == or_mask));

   a_r5_one_and_flip : assert property (@(posedge clk) disable iff (rst)
      $countones(and_mask_f ^ and_mask) <= 1);

   a_r7_one_or_flip : assert property (@(posedge clk) disable iff (rst)
      $countones(or_mask_f ^ or_mask) <= 1);

   a_r11_single_line_fault : assert property (@(posedge clk) disable iff (rst)
      $onehot0({in_br, inv_br, pt_br, out_br, in_sm, inv_sm, pt_sm, out_sm}));
endmodule

// File: rtl/pla_line_fault.sv
module pla_line_fault #(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] sm,
   input  logic         sv,
   input  logic [W-2:0] br,
   input  logic         br_or,
   output logic [W-1:0] y
);
   logic [W-2:0] pair_v;

   for (genvar i = 0; i < W - 1; i++) begin : g_pair
      assign pair_v[i] = br_or ? (a[i] | a[i+1]) : (a[i] & a[i+1]);
   end

   for (genvar i = 0; i < W; i++) begin : g_line
      if (i == 0) begin : g_first
         assign y[i] = sm[i] ? sv : (br[i] ? pair_v[i] : a[i]);
      end else if (i == W - 1) begin : g_last
         assign y[i] = sm[i] ? sv : (br[i-1] ? pair_v[i-1] : a[i]);
      end else begin : g_mid
         assign y[i] = sm[i] ? sv :
                       br[i]   ? pair_v[i]   :
                       br[i-1] ? pair_v[i-1] : a[i];
      end
   end
endmodule

// File: rtl/pla_eval.sv
module pla_eval #(
   parameter int N_IN  = 4,
   parameter int N_PT  = 8,
   parameter int N_OUT = 3
) (
   input  logic [N_IN-1:0]             pi,
   input  logic [N_PT-1:0][2*N_IN-1:0] and_m,
   input  logic [N_OUT-1:0][N_PT-1:0]  or_m,
   input  logic [N_IN-1:0]             in_sm,
   input  logic [N_IN-1:0]             inv_sm,
   input  logic [N_PT-1:0]             pt_sm,
   input  logic [N_OUT-1:0]            out_sm,
   input  logic                        sv,
   input  logic [N_IN-2:0]             in_br,
   input  logic [N_IN-2:0]             inv_br,
   input  logic [N_PT-2:0]             pt_br,
   input  logic [N_OUT-2:0]            out_br,
   input  logic                        br_or,
   output logic [N_OUT-1:0]            y
);
   logic [N_IN-1:0]    true_l, comp_raw, comp_l;
   logic [2*N_IN-1:0]  lits;
   logic [N_PT-1:0]    pt_raw, pt_l;
   logic [N_OUT-1:0]   out_raw;

   pla_line_fault #(.W(N_IN)) u_in_lines (
      .a(pi), .sm(in_sm), .sv(sv), .br(in_br), .br_or(br_or), .y(true_l));

   assign comp_raw = ~true_l;

   pla_line_fault #(.W(N_IN)) u_inv_lines (
      .a(comp_raw), .sm(inv_sm), .sv(sv), .br(inv_br), .br_or(br_or), .y(comp_l));

   assign lits = {comp_l, true_l};

   for (genvar p = 0; p < N_PT; p++) begin : g_prod
      assign pt_raw[p] = &(lits | ~and_m[p]);
   end

   pla_line_fault #(.W(N_PT)) u_pt_lines (
      .a(pt_raw), .sm(pt_sm), .sv(sv), .br(pt_br), .br_or(br_or), .y(pt_l));

   for (genvar o = 0; o < N_OUT; o++) begin : g_sum
      assign out_raw[o] = |(pt_l & or_m[o]);
   end

   pla_line_fault #(.W(N_OUT)) u_out_lines (
      .a(out_raw), .sm(out_sm), .sv(sv), .br(out_br), .br_or(br_or), .y(y));
endmodule

// File: rtl/pla_fault_array.sv
module pla_fault_array
   import pla_pkg::*;
#(
   parameter  int N_IN  = 4,
   parameter  int N_PT  = 8,
   parameter  int N_OUT = 3,
   localparam int SEL_W = sel_width(N_IN, N_PT, N_OUT)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic             cfg_plane,
   input  logic [SEL_W-1:0] cfg_row,
   input  logic [SEL_W-1:0] cfg_col,
   input  logic             cfg_bit,
   input  logic [N_IN-1:0]  pi,
   input  logic             flt_en,
   input  logic [1:0]       flt_kind,
   input  logic [1:0]       flt_cls,
   input  logic [SEL_W-1:0] flt_row,
   input  logic [SEL_W-1:0] flt_col,
   input  logic [SEL_W-1:0] flt_idx,
   input  logic             flt_val,
   output logic [N_OUT-1:0] good_o,
   output logic [N_OUT-1:0] bad_o,
   output logic             diff_o,
   output logic [N_OUT-1:0] good_q,
   output logic [N_OUT-1:0] bad_q,
   output logic             diff_q
);
   if (N_IN < 2)  begin : g_chk_in  $error("N_IN must be at least 2");  end
   if (N_PT < 2)  begin : g_chk_pt  $error("N_PT must be at least 2");  end
   if (N_OUT < 2) begin : g_chk_out $error("N_OUT must be at least 2"); end

   logic [N_PT-1:0][2*N_IN-1:0] and_mask, and_mask_f;
   logic [N_OUT-1:0][N_PT-1:0]  or_mask, or_mask_f;
   logic [N_IN-1:0]  in_sm, inv_sm;
   logic [N_PT-1:0]  pt_sm;
   logic [N_OUT-1:0] out_sm;
   logic             stuck_val, br_or;
   logic [N_IN-2:0]  in_br, inv_br;
   logic [N_PT-2:0]  pt_br;
   logic [N_OUT-2:0] out_br;

   pla_plane_store #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_store (
      .clk(clk), .rst(rst), .we(cfg_we), .plane(cfg_plane), .row(cfg_row),
      .col(cfg_col), .bitv(cfg_bit), .and_mask(and_mask), .or_mask(or_mask));

   pla_fault_ctl #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_fctl (
      .clk(clk), .rst(rst), .en(flt_en), .kind(flt_kind), .cls(flt_cls),
      .row(flt_row), .col(flt_col), .idx(flt_idx), .val(flt_val),
      .and_mask(and_mask), .or_mask(or_mask),
      .and_mask_f(and_mask_f), .or_mask_f(or_mask_f),
      .in_sm(in_sm), .inv_sm(inv_sm), .pt_sm(pt_sm), .out_sm(out_sm),
      .stuck_val(stuck_val), .in_br(in_br), .inv_br(inv_br), .pt_br(pt_br),
      .out_br(out_br), .br_or(br_or));

   pla_eval #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT)) u_ref_eval (
      .pi(pi), .and_m(and_mask), .or_m(or_mask),
      .in_sm('0), .inv_sm('0), .pt_sm('0), .out_sm('0), .sv(1'b0),
      .in_br('0), .inv_br('0), .pt_br('0), .out_br('0), .br_or(1'b0),
      .y(good_o));

   pla_eval #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT)) u_flt_eval (
      .pi(pi), .and_m(and_mask_f), .or_m(or_mask_f),
      .in_sm(in_sm), .inv_sm(inv_sm), .pt_sm(pt_sm), .out_sm(out_sm), .sv(stuck_val),
      .in_br(in_br), .inv_br(inv_br), .pt_br(pt_br), .out_br(out_br), .br_or(br_or),
      .y(bad_o));

   assign diff_o = (good_o != bad_o);

   always_ff @(posedge clk) begin
      if (rst) begin
         good_q <= '0;
         bad_q  <= '0;
         diff_q <= 1'b0;
      end else begin
         good_q <= good_o;
         bad_q  <= bad_o;
         diff_q <= diff_o;
      end
   end

   a_r3_clean_when_disabled : assert property (@(posedge clk) disable iff (rst)
      !flt_en |-> (bad_o == good_o));

   a_r12_registered_flag : assert property (@(posedge clk) disable iff (rst)
      diff_q == (good_q != bad_q));

   a_r13_ref_ignores_fault : assert property (@(posedge clk) disable iff (rst)
      (!$past(cfg_we) && $stable(pi)) |-> $stable(good_o));
endmodule

// File: tb/sim_pla_fault_array.sv
`timescale 1ns/1ps
module sim_pla_fault_array;
   localparam int N_IN  = 4;
   localparam int N_PT  = 8;
   localparam int N_OUT = 3;
   localparam int SEL_W = 3;
   localparam int N_LIT = 2 * N_IN;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_we = 1'b0, cfg_plane = 1'b0, cfg_bit = 1'b0;
   logic [SEL_W-1:0] cfg_row = '0, cfg_col = '0;
   logic [N_IN-1:0]  pi = '0;
   logic flt_en = 1'b0, flt_val = 1'b0;
   logic [1:0] flt_kind = 2'd0, flt_cls = 2'd0;
   logic [SEL_W-1:0] flt_row = '0, flt_col = '0, flt_idx = '0;
   logic [N_OUT-1:0] good_o, bad_o, good_q, bad_q;
   logic diff_o, diff_q;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   bit am [N_PT][N_LIT];
   bit om [N_OUT][N_PT];
   logic [2*N_OUT:0] sb_q[$];

   always #2.5 clk = ~clk;

   pla_fault_array #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT)) u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
      .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_bit(cfg_bit), .pi(pi),
      .flt_en(flt_en), .flt_kind(flt_kind), .flt_cls(flt_cls),
      .flt_row(flt_row), .flt_col(flt_col), .flt_idx(flt_idx), .flt_val(flt_val),
      .good_o(good_o), .bad_o(bad_o), .diff_o(diff_o),
      .good_q(good_q), .bad_q(bad_q), .diff_q(diff_q));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h (pi=%0h kind=%0d cls=%0d)",
                  req, act, exp, pi, flt_kind, flt_cls);
      end
   endtask

   // Independent model of the line-level faults of one class
   function automatic logic [7:0] lines(input logic [7:0] v, input int w, input int cls);
      int k;
      logic b;
      k = int'(flt_idx);
      if (flt_en && int'(flt_cls) == cls) begin
         if (flt_kind == 2'd2 && k < w) v[k] = flt_val;
         if (flt_kind == 2'd3 && k + 1 < w) begin
            b = flt_val ? (v[k] | v[k+1]) : (v[k] & v[k+1]);
            v[k] = b;
            v[k+1] = b;
         end
      end
      return v;
   endfunction

   function automatic logic [N_OUT-1:0] model(input logic [N_IN-1:0] x, input bit faulty);
      logic [7:0] t, c, p, y;
      bit m;
      t = {4'b0, x};
      if (faulty) t = lines(t, N_IN, 0);
      c = ~t;
      if (faulty) c = lines(c, N_IN, 1);
      p = '0;
      for (int i = 0; i < N_PT; i++) begin
         p[i] = 1'b1;
         for (int j = 0; j < N_LIT; j++) begin
            m = am[i][j];
            if (faulty && flt_en && flt_kind == 2'd0 && int'(flt_row) == i && int'(flt_col) == j)
               m = !m;
            if (m) p[i] = p[i] & ((j < N_IN) ? t[j] : c[j-N_IN]);
         end
      end
      if (faulty) p = lines(p, N_PT, 2);
      y = '0;
      for (int o = 0; o < N_OUT; o++)
         for (int i = 0; i < N_PT; i++) begin
            m = om[o][i];
            if (faulty && flt_en && flt_kind == 2'd1 && int'(flt_row) == o && int'(flt_col) == i)
               m = !m;
            if (m) y[o] = y[o] | p[i];
         end
      if (faulty) y = lines(y, N_OUT, 3);
      return y[N_OUT-1:0];
   endfunction

   task automatic cfg_write(input bit plane, input int row, input int col, input bit v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_plane = plane; cfg_row = SEL_W'(row);
      cfg_col = SEL_W'(col); cfg_bit = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!plane && row < N_PT && col < N_LIT) am[row][col] = v;
      if (plane && row < N_OUT && col < N_PT) om[row][col] = v;
   endtask

   task automatic set_fault(input bit en, input int kind, input int cls,
                            input int row, input int col, input int idx, input bit v);
      @(negedge clk);
      flt_en = en; flt_kind = 2'(kind); flt_cls = 2'(cls);
      flt_row = SEL_W'(row); flt_col = SEL_W'(col); flt_idx = SEL_W'(idx); flt_val = v;
   endtask

   // Driver: apply one vector, check combinational results, queue registered ones
   task automatic apply(input string req, input logic [N_IN-1:0] x);
      logic [N_OUT-1:0] eg, eb;
      @(negedge clk);
      pi = x;
      #1;
      eg = model(x, 1'b0);
      eb = model(x, 1'b1);
      check({req, " R13 good"}, 8'(good_o), 8'(eg));
      check({req, " bad"}, 8'(bad_o), 8'(eb));
      check({req, " R12 diff"}, 8'(diff_o), 8'(eg != eb));
      sb_q.push_back({eg, eb, (eg != eb)});
   endtask

   task automatic sweep(input string req);
      for (int v = 0; v < (1 << N_IN); v++) apply(req, N_IN'(v));
   endtask

   // Monitor: pop and compare the registered copy one clock later
   initial begin
      logic [2*N_OUT:0] e;
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check("R12 good_q", 8'(good_q), 8'(e[2*N_OUT:N_OUT+1]));
            check("R12 bad_q", 8'(bad_q), 8'(e[N_OUT:1]));
            check("R12 diff_q", 8'(diff_q), 8'(e[0]));
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N_PT; i++) for (int j = 0; j < N_LIT; j++) am[i][j] = 0;
      for (int o = 0; o < N_OUT; o++) for (int i = 0; i < N_PT; i++) om[o][i] = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1 reset good_o", 8'(good_o), 8'h0);
      check("R1 reset bad_o", 8'(bad_o), 8'h0);
      check("R1 reset good_q", 8'(good_q), 8'h0);
      sweep("R1 empty planes");

      // P0 = x0 & ~x1, P1 = x1 & x2, P2 = ~x3, P3 = x0 & x3
      cfg_write(0, 0, 0, 1); cfg_write(0, 0, 5, 1);
      cfg_write(0, 1, 1, 1); cfg_write(0, 1, 2, 1);
      cfg_write(0, 2, 7, 1);
      cfg_write(0, 3, 0, 1); cfg_write(0, 3, 3, 1);
      // Y0 = P0|P1, Y1 = P1|P2, Y2 = P3
      cfg_write(1, 0, 0, 1); cfg_write(1, 0, 1, 1);
      cfg_write(1, 1, 1, 1); cfg_write(1, 1, 2, 1);
      cfg_write(1, 2, 3, 1);
      cfg_write(1, 6, 0, 1);  // out of range row: ignored (R2)
      sweep("R2 programmed");

      set_fault(0, 2, 3, 0, 0, 0, 1);
      sweep("R3 fault disabled");
      set_fault(1, 0, 0, 0, 5, 0, 0);
      sweep("R4 growth");
      set_fault(1, 0, 0, 1, 6, 0, 0);
      sweep("R5 contradiction");
      set_fault(1, 0, 0, 2, 0, 0, 0);
      sweep("R5 shrinkage");
      set_fault(1, 1, 0, 1, 1, 0, 0);
      sweep("R6 disappearance");
      set_fault(1, 1, 0, 2, 2, 0, 0);
      sweep("R7 appearance");
      set_fault(1, 1, 0, 2, 4, 0, 0);
      sweep("R7 empty product added");
      set_fault(1, 2, 0, 0, 0, 1, 1);
      sweep("R8 input stuck1");
      set_fault(1, 2, 0, 0, 0, 0, 0);
      sweep("R8 input stuck0");
      set_fault(1, 2, 1, 0, 0, 3, 1);
      sweep("R9 inverter stuck1");
      set_fault(1, 2, 2, 0, 0, 1, 0);
      sweep("R10 product stuck0");
      set_fault(1, 2, 3, 0, 0, 2, 1);
      sweep("R10 output stuck1");
      set_fault(1, 2, 3, 0, 0, 5, 1);
      sweep("R10 index out of range");
      set_fault(1, 3, 0, 0, 0, 0, 0);
      sweep("R11 input wired-AND");
      set_fault(1, 3, 2, 0, 0, 1, 1);
      sweep("R11 product wired-OR");
      set_fault(1, 3, 1, 0, 0, 2, 1);
      sweep("R11 inverter wired-OR");
      set_fault(1, 3, 3, 0, 0, 0, 0);
      sweep("R11 output wired-AND");
      set_fault(1, 3, 3, 0, 0, 2, 1);
      sweep("R11 no partner line");

      set_fault(0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule